// File: doc/BRIEF.md
# Single-to-Half Precision Pair Packer

This block takes two IEEE single-precision values and turns each into an IEEE half-precision value. It then places the two 16-bit results side by side in one 32-bit word. Each lane first splits its input into sign, 8-bit biased exponent and 23-bit fraction. It then picks one of four cases: a NaN, a magnitude too small for a half normal, a magnitude in the half normal range, or a magnitude too large for a half. Every rounding step is round-to-nearest with ties to even.

Results below the smallest half normal become half subnormals; they are not flushed to zero. Single-precision subnormal inputs are handled as well. In the normal range, a rounding carry out of the 10-bit fraction moves into the exponent field, so a value just above the largest finite half rounds to infinity. The input side is two words qualified by one valid strobe. The output word is registered and appears one cycle later with its own valid.

Top module: `half_pair_packer`

## Requirements
- R1: The half converted from `in_lo` occupies `out_word[15:0]` and the half converted from `in_hi` occupies `out_word[31:16]`.
- R2: Each half's sign bit (bit 15 of the half) equals bit 31 of its input word, in every case including NaN and infinity.
- R3: An input with exponent field (bits 30:23) equal to 255 and a nonzero fraction field (bits 22:0) gives half magnitude bits [14:0] = 0x7FFF.
- R4: An input with exponent field 143 or above that is not a NaN (infinity included) gives half magnitude 0x7C00.
- R5: An input with exponent field from 113 to 142 gives magnitude ((exponent − 112) << 10) plus the fraction divided by 2^13 and rounded to nearest even, with the carry adding into the exponent field; 0x477FE000 gives 0x7BFF and 0x477FF000 gives 0x7C00.
- R6: An input with exponent field below 113, single subnormals included, gives magnitude equal to |value|·2^24 rounded to nearest even; this covers zero and half subnormals, and 0x387FF000 rounds up to 0x0400.
- R7: Exact halfway cases round to the even neighbour in both paths: 0x3F801000 gives 0x3C00, 0x3F803000 gives 0x3C02, 0x33C00000 gives 0x0002 and 0x34200000 gives 0x0002.
- R8: `out_valid` is `in_valid` delayed by one clock, and the word captured with `in_valid` high appears on `out_word` in that same following cycle.
- R9: While `in_valid` is low, `out_word` keeps its previous value.
- R10: A clock edge with `rst_n` low clears `out_valid` and `out_word` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_lo` and `in_hi` |
| in_lo | input | 32 | First single-precision operand, packed into the low half |
| in_hi | input | 32 | Second single-precision operand, packed into the high half |
| out_valid | output | 1 | High one cycle after an accepted input |
| out_word | output | 32 | Two packed half-precision results |

## Verification
The bench builds the block with its default settings, which fix two lanes and the standard single and half field widths. With these settings, every one of the 256 exponent codes can be visited on both lanes. For each code the bench drives fixed fraction patterns (zero, one, all ones, exact ties and values just off the ties) together with pseudo-random fractions and signs. This reaches every boundary between the four cases, the single-subnormal inputs, and the two carry points: subnormal to normal, and largest finite to infinity. Expected halves come from an exact real-number model that finds the binade and rounds there, which is a different route from the shift-and-sticky logic in the design.

// File: rtl/hpk_pkg.sv
// Package: shared field widths, case boundaries and constants for the
// single-to-half pair packer. Assumes IEEE binary32 and binary16 layouts.
package hpk_pkg;
    localparam int F32_W       = 32;
    localparam int F32_EXP_W   = 8;
    localparam int F32_MAN_W   = 23;
    localparam int F32_BIAS    = 127;
    localparam int F16_W       = 16;
    localparam int F16_EXP_W   = 5;
    localparam int F16_MAN_W   = 10;
    localparam int F16_BIAS    = 15;
    localparam int NUM_LANES   = 2;

    localparam int MAG_W       = F16_W - 1;
    localparam int SIG_W       = F32_MAN_W + 1;
    localparam int DROP_W      = F32_MAN_W - F16_MAN_W;
    localparam int BIAS_DELTA  = F32_BIAS - F16_BIAS;
    localparam int TINY_LIMIT  = BIAS_DELTA + 1;
    localparam int HUGE_LIMIT  = BIAS_DELTA + (1 << F16_EXP_W) - 1;
    localparam int SUB_SCALE   = F16_BIAS - 1 + F16_MAN_W;
    localparam int TINY_BASE   = F32_BIAS + F32_MAN_W - SUB_SCALE;
    localparam int SHIFT_CAP   = SIG_W + 2;
    localparam int EXT_W       = SIG_W + SHIFT_CAP;
    localparam logic [F32_EXP_W-1:0] EXP_ALL1 = '1;

    localparam logic [MAG_W-1:0] MAG_NAN = '1;
    localparam logic [MAG_W-1:0] MAG_INF = {{F16_EXP_W{1'b1}}, {F16_MAN_W{1'b0}}};
    localparam logic [MAG_W-1:0] MAG_MIN_NORM = MAG_W'(1) << F16_MAN_W;

    typedef enum logic [1:0] {
        CASE_NAN  = 2'd0,
        CASE_TINY = 2'd1,
        CASE_NORM = 2'd2,
        CASE_HUGE = 2'd3
    } lane_case_e;
endpackage

// File: rtl/hpk_tiny_path.sv
// Module: magnitude for inputs below the smallest half normal.
// Computes round-to-nearest-even of |value| * 2^24 by shifting the full
// significand (hidden one included) and keeping guard and sticky bits.
// Assumes the caller only uses the result when the exponent is below
// TINY_LIMIT; the output is then at most MAG_MIN_NORM.
module hpk_tiny_path
    import hpk_pkg::*;
(
    input  logic [F32_EXP_W-1:0] exp_i,
    input  logic [F32_MAN_W-1:0] man_i,
    output logic [MAG_W-1:0]     mag_o
);
    logic [SIG_W-1:0] sig;
    logic [7:0]       shamt;
    logic [EXT_W-1:0] ext;
    logic [SIG_W-1:0] kept;
    logic             guard;
    logic             sticky;
    logic             round_up;

    // Shift distance: single subnormals use exponent 1 with no hidden one.
    always_comb begin
        sig = {(exp_i != '0), man_i};
        if (exp_i == '0) begin
            shamt = 8'(TINY_BASE - 1);
        end else if (exp_i >= 8'(TINY_BASE)) begin
            shamt = 8'd0;
        end else begin
            shamt = 8'(TINY_BASE) - exp_i;
        end
        if (shamt > 8'(SHIFT_CAP)) begin
            shamt = 8'(SHIFT_CAP);
        end
    end

    // Align, split kept bits from the dropped fraction, round to even.
    always_comb begin
        ext      = {sig, {SHIFT_CAP{1'b0}}} >> shamt;
        kept     = ext[EXT_W-1 -: SIG_W];
        guard    = ext[SHIFT_CAP-1];
        sticky   = |ext[SHIFT_CAP-2:0];
        round_up = guard & (sticky | kept[0]);
        mag_o    = kept[MAG_W-1:0] + MAG_W'(round_up);
    end
endmodule

// File: rtl/hpk_lane.sv
// Module: one single-to-half conversion lane (combinational).
// Classifies the input into NaN / tiny / normal / huge and selects the
// matching magnitude; the sign is carried over unchanged.
// Assumes a binary32 input word; produces a binary16 word.
module hpk_lane
    import hpk_pkg::*;
(
    input  logic [F32_W-1:0] f_i,
    output logic [F16_W-1:0] h_o
);
    logic                 sgn;
    logic [F32_EXP_W-1:0] exp_f;
    logic [F32_MAN_W-1:0] man_f;
    lane_case_e           lane_case;
    logic [MAG_W-1:0]     tiny_mag;
    logic [MAG_W-1:0]     norm_mag;
    logic [F32_EXP_W-1:0] exp_rebias;
    logic                 norm_up;
    logic [MAG_W-1:0]     mag;

    assign {sgn, exp_f, man_f} = f_i;

    // Pick the conversion case from the raw exponent and fraction.
    always_comb begin
        if (exp_f == EXP_ALL1 && man_f != '0) begin
            lane_case = CASE_NAN;
        end else if (exp_f < F32_EXP_W'(TINY_LIMIT)) begin
            lane_case = CASE_TINY;
        end else if (exp_f < F32_EXP_W'(HUGE_LIMIT)) begin
            lane_case = CASE_NORM;
        end else begin
            lane_case = CASE_HUGE;
        end
    end

    hpk_tiny_path u_tiny (
        .exp_i (exp_f),
        .man_i (man_f),
        .mag_o (tiny_mag)
    );

    // Normal path: rebias exponent, drop 13 fraction bits with RNE; the
    // addition lets a fraction carry ripple into the exponent field.
    always_comb begin
        exp_rebias = exp_f - F32_EXP_W'(BIAS_DELTA);
        norm_up    = man_f[DROP_W-1] &
                     ((|man_f[DROP_W-2:0]) | man_f[DROP_W]);
        norm_mag   = {exp_rebias[F16_EXP_W-1:0], man_f[F32_MAN_W-1:DROP_W]}
                     + MAG_W'(norm_up);
    end

    // Final magnitude select and sign attach.
    always_comb begin
        unique case (lane_case)
            CASE_NAN:  mag = MAG_NAN;
            CASE_TINY: mag = tiny_mag;
            CASE_NORM: mag = norm_mag;
            default:   mag = MAG_INF;
        endcase
        h_o = {sgn, mag};
    end

    // Cross-path bounds between the classifier and each rounding path.
    always_comb begin
        if (lane_case == CASE_TINY) begin
            assert_tiny_bounded_R6: assert (tiny_mag <= MAG_MIN_NORM);
        end
        if (lane_case == CASE_NORM) begin
            assert_norm_bounded_R5: assert (norm_mag >= MAG_MIN_NORM && norm_mag <= MAG_INF);
        end
    end
endmodule

// File: rtl/half_pair_packer.sv
// Module: top of the pair packer. Converts two binary32 operands to
// binary16 in parallel lanes and registers the packed word under valid.
// Assumes in_lo/in_hi are meaningful only while in_valid is high.
module half_pair_packer
    import hpk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [F32_W-1:0] in_lo,
    input  logic [F32_W-1:0] in_hi,
    output logic             out_valid,
    output logic [F32_W-1:0] out_word
);
    logic [NUM_LANES-1:0][F32_W-1:0] lane_in;
    logic [NUM_LANES-1:0][F16_W-1:0] lane_out;

    assign lane_in[0] = in_lo;
    assign lane_in[1] = in_hi;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        hpk_lane u_lane (
            .f_i (lane_in[g]),
            .h_o (lane_out[g])
        );
    end

    // Output register: valid follows input valid, data loads on valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= lane_out;
            end
        end
    end

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word));
    assert_sign_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_word[15] == $past(in_lo[31]));
    assert_sign_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_word[31] == $past(in_hi[31]));
    assert_nan_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_lo[30:23] == 8'hFF && in_lo[22:0] != '0)
        |=> out_word[14:0] == 15'h7FFF);
    assert_overflow_inf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_hi[30:23] >= 8'd143 &&
         !(in_hi[30:23] == 8'hFF && in_hi[22:0] != '0))
        |=> out_word[30:16] == 15'h7C00);
endmodule

// File: tb/half_pair_packer_tb.sv
module half_pair_packer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_lo = '0;
    logic [31:0] in_hi = '0;
    logic        out_valid;
    logic [31:0] out_word;

    int checks = 0;
    int errors = 0;
    logic [31:0] rng = 32'h1234_5678;
    bit done = 1'b0;

    always #4 clk = ~clk;

    half_pair_packer dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_lo(in_lo), .in_hi(in_hi),
        .out_valid(out_valid), .out_word(out_word)
    );

    function automatic logic [31:0] next_rand();
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        return rng;
    endfunction

    // Round to nearest, ties to even, on a non-negative real.
    function automatic longint rne(real q);
        real fl;
        real d;
        longint r;
        fl = $floor(q);
        d  = q - fl;
        r  = longint'(fl);
        if (d > 0.5 || (d == 0.5 && r[0])) r = r + 1;
        return r;
    endfunction

    // Reference model: exact value, then binade search and rounding.
    function automatic logic [15:0] ref_half(logic [31:0] f);
        int e;
        int m;
        real v;
        int k;
        longint r;
        logic [14:0] mag;
        e = int'(f[30:23]);
        m = int'(f[22:0]);
        if (e == 255) begin
            mag = (m != 0) ? 15'h7FFF : 15'h7C00;
        end else begin
            if (e == 0) v = real'(m) * (2.0 ** (-149));
            else        v = (8388608.0 + real'(m)) * (2.0 ** (e - 150));
            if (v >= 65520.0) begin
                mag = 15'h7C00;
            end else if (v < 2.0 ** (-14)) begin
                r = rne(v * (2.0 ** 24));
                mag = 15'(r);
            end else begin
                k = -14;
                while (k < 15 && v >= 2.0 ** (k + 1)) k++;
                r = rne((v / (2.0 ** k)) * 1024.0 - 1024.0);
                mag = 15'((longint'(k + 15) << 10) + r);
            end
        end
        return {f[31], mag};
    endfunction

    function automatic string tag_of(logic [31:0] f);
        if (f[30:23] == 8'hFF && f[22:0] != 0) return "R3";
        if (f[30:23] >= 8'd143) return "R4";
        if (f[30:23] >= 8'd113) return "R5";
        return "R6";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Drive one pair, then check the registered result one cycle later.
    task automatic apply(logic [31:0] lo, logic [31:0] hi, string tag_lo, string tag_hi);
        @(negedge clk);
        in_valid = 1'b1;
        in_lo = lo;
        in_hi = hi;
        @(negedge clk);
        chk("R8", {31'd0, out_valid}, 32'd1);
        chk(tag_lo, {16'd0, out_word[15:0]}, {16'd0, ref_half(lo)});
        chk(tag_hi, {16'd0, out_word[31:16]}, {16'd0, ref_half(hi)});
    endtask

    initial begin
        logic [31:0] held;
        logic [22:0] pats [12];
        pats = '{23'h000000, 23'h000001, 23'h7FFFFF, 23'h400000, 23'h001000,
                 23'h003000, 23'h000FFF, 23'h001001, 23'h7FF000, 23'h7FE000,
                 23'h2AAAAA, 23'h555555};
        // R10: reset clears outputs even with valid asserted
        in_valid = 1'b1;
        in_lo = 32'h3F80_0000;
        in_hi = 32'h4000_0000;
        repeat (3) @(negedge clk);
        chk("R10", {31'd0, out_valid}, 32'd0);
        chk("R10", out_word, 32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1: lane placement with distinct values
        apply(32'h3F80_0000, 32'hC000_0000, "R1", "R1");
        chk("R1", out_word, 32'hC000_3C00);

        // R2: sign carried through NaN, infinity, zero
        apply(32'hFFC0_0001, 32'hFF80_0000, "R2", "R2");
        apply(32'h8000_0000, 32'h8000_0001, "R2", "R2");

        // R5 carry and boundaries; R6 carry to smallest normal
        apply(32'h477F_E000, 32'h477F_F000, "R5", "R5");
        chk("R5", out_word, 32'h7C00_7BFF);
        apply(32'h387F_F000, 32'h3880_0000, "R6", "R5");
        chk("R6", out_word, 32'h0400_0400);

        // R7: ties to even in both paths
        apply(32'h3F80_1000, 32'h3F80_3000, "R7", "R7");
        chk("R7", out_word, 32'h3C02_3C00);
        apply(32'h33C0_0000, 32'h3420_0000, "R7", "R7");
        chk("R7", out_word, 32'h0002_0002);

        // R9: idle cycles keep the last word
        held = out_word;
        @(negedge clk);
        in_valid = 1'b0;
        in_lo = 32'h4120_0000;
        in_hi = 32'h7FC0_0000;
        @(negedge clk);
        chk("R8", {31'd0, out_valid}, 32'd0);
        chk("R9", out_word, held);
        @(negedge clk);
        chk("R9", out_word, held);

        // Sweep every exponent with pattern and random fractions, both lanes
        for (int e = 0; e < 256; e++) begin
            for (int p = 0; p < 16; p++) begin
                logic [31:0] r1;
                logic [31:0] r2;
                logic [31:0] a;
                logic [31:0] b;
                r1 = next_rand();
                r2 = next_rand();
                a = {r1[31], 8'(e), (p < 12) ? pats[p] : r1[22:0]};
                b = {r2[31], 8'(255 - e), (p < 12) ? pats[11 - p] : r2[22:0]};
                apply(a, b, tag_of(a), tag_of(b));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule